// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple synchronous host request port and an external asynchronous static RAM that is 16 bits wide, with 19 address bits, an active-low and an active-high chip select, and one active-low enable per byte lane. It takes one request at a time: an address, write data, a per-lane mask and a read/write flag, under a valid/ready handshake. It plays each request out as chip-select, write-strobe, output-enable and lane-enable waveforms whose lengths are whole clock counts. Each count is derived from a nanosecond minimum and the clock period, rounded up. A read comes back as a one-cycle response pulse with the sampled word.

After reset the controller keeps the memory deselected for the power-up hold before it raises ready. Between accesses it always lets chip select go inactive for at least the minimum high pulse. It also keeps track of how long minimum-length cycles have run without a break. Before that span could exceed the continuous-cycling limit, it holds ready low long enough to give the memory a rest gap.

The controller is a five-state machine. ST_PWRUP waits for the power-up hold and then moves to ST_IDLE. ST_IDLE accepts a request when ready and moves to ST_WRITE or ST_READ. ST_WRITE and ST_READ each hold their strobes for the access count and then move to ST_RECOVER. ST_RECOVER holds chip select high for the gap count and then returns to ST_IDLE.

Top module: `sram_byte_ctl`

## Requirements
- R1: After reset release, req_ready stays low and the memory stays deselected (sram_cs1_n=1, sram_cs2=0, sram_we_n=1). req_ready first reads high after exactly PWR_CYC rising edges, where PWR_CYC is 200 µs rounded up to clocks (10000 at 50 MHz).
- R2: A request is taken only on a rising edge where req_valid and req_ready are both high. A req_valid raised while req_ready is low (for example during power-up) and dropped again has no effect on the memory. req_ready is low throughout an access.
- R3: A write with a nonzero mask holds sram_cs1_n=0, sram_cs2=1, sram_we_n=0 and sram_oe_n=1, with sram_addr and sram_dq_out stable, for WR_CYC consecutive cycles starting the cycle after acceptance. WR_CYC is the largest of the rounded-up write-strobe (50 ns), select-to-end (60 ns), data-setup (20 ns) and cycle-time (70 ns) minimums, which is 4 at 50 MHz.
- R4: A read with a nonzero mask holds chip select active, sram_oe_n=0 and sram_we_n=1 for RD_CYC cycles. RD_CYC is the largest of the rounded-up access (70 ns), output-enable (25 ns) and cycle-time minimums, which is 4 at 50 MHz. The word is sampled at the end of the last of those cycles, and rsp_valid is high for exactly the next cycle with that word on rsp_rdata.
- R5: Mask bit 0 selects lane 0 (data bits 7:0, sram_be_n[0] low) and mask bit 1 selects lane 1 (bits 15:8, sram_be_n[1] low). A write changes only the selected lanes. A read returns zero in unselected lanes.
- R6: A mask of 00 is a standby request. It is accepted and runs its state sequence, but it never asserts chip select, write strobe or output enable. A write leaves memory unchanged, and a read returns rsp_valid with an all-zero word. A strobe is never asserted with both lane enables high.
- R7: After every access, chip select is inactive for at least CP_CYC cycles (10 ns rounded up, 1 at 50 MHz) with req_ready low. req_ready returns in the following cycle.
- R8: sram_dq_oe is high only while sram_we_n is low. It is low in the cycle before sram_oe_n falls.
- R9: Under back-to-back requests, no span between two rests is longer than BURST_CYC cycles (80 µs, 4000 at 50 MHz). A rest is at least REST_CYC consecutive cycles (one cycle time, 4 at 50 MHz) with chip select inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane select, bit i for bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_be_n | output | DATA_W/8 | Active-low lane enables, bit 0 = lower byte |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | DATA_W | Data from the memory |

## Verification
Most state faults show up as a strobe width that is wrong by a whole clock. A timer that is off by one stretches or cuts sram_we_n or sram_oe_n by a cycle within that same access, and a wrong next state skips ST_RECOVER, so the chip-select gap vanishes at once. If the data driver is left on during a read, the fault is visible the first cycle output enable falls. A broken lane decode shows up on the next read as a wrong byte or a nonzero unselected lane. The two slow counters only show late. A bad power-up count appears as a wrong first-ready cycle near ten thousand clocks. A bad run guard appears only after about four thousand cycles of continuous requests, as a missing rest gap.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_RECOVER
    } ctl_state_t;

    // Minimum time in ns converted to clock counts, rounded up, at least 1.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_run_guard.sv
module sram_ctl_run_guard #(
    parameter int LIMIT = 4000,
    parameter int REST  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rest_cycle,
    output logic block
);
    localparam int RW = $clog2(LIMIT + 1) + 1;
    localparam int SW = $clog2(REST + 1) + 1;

    logic [RW-1:0] run_cnt;
    logic [SW-1:0] rest_cnt;
    logic          rest_done;

    assign rest_done = rest_cycle && (rest_cnt == SW'(REST - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            run_cnt  <= '0;
            rest_cnt <= '0;
        end else begin
            if (rest_done)
                run_cnt <= '0;
            else if (run_cnt < RW'(LIMIT))
                run_cnt <= run_cnt + 1'b1;

            if (!rest_cycle || rest_done)
                rest_cnt <= '0;
            else
                rest_cnt <= rest_cnt + 1'b1;
        end
    end

    assign block = (run_cnt >= RW'(LIMIT));
endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 16,
    parameter int CLK_PS      = 20000,
    parameter int T_PWRUP_NS  = 200000,
    parameter int T_CYCLE_NS  = 70,
    parameter int T_WP_NS     = 50,
    parameter int T_CW_NS     = 60,
    parameter int T_DW_NS     = 20,
    parameter int T_ACC_NS    = 70,
    parameter int T_OE_NS     = 25,
    parameter int T_CP_NS     = 10,
    parameter int T_BURST_NS  = 80000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_cs1_n,
    output logic                sram_cs2,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic [DATA_W/8-1:0] sram_be_n,
    output logic [DATA_W-1:0]   sram_dq_out,
    output logic                sram_dq_oe,
    input  logic [DATA_W-1:0]   sram_dq_in
);
    localparam int LANES     = DATA_W / 8;
    localparam int PWR_CYC   = ns_to_cyc(T_PWRUP_NS, CLK_PS);
    localparam int RC_CYC    = ns_to_cyc(T_CYCLE_NS, CLK_PS);
    localparam int WP_CYC    = ns_to_cyc(T_WP_NS, CLK_PS);
    localparam int CW_CYC    = ns_to_cyc(T_CW_NS, CLK_PS);
    localparam int DW_CYC    = ns_to_cyc(T_DW_NS, CLK_PS);
    localparam int AA_CYC    = ns_to_cyc(T_ACC_NS, CLK_PS);
    localparam int OE_CYC    = ns_to_cyc(T_OE_NS, CLK_PS);
    localparam int CP_CYC    = ns_to_cyc(T_CP_NS, CLK_PS);
    localparam int BURST_CYC = ns_to_cyc(T_BURST_NS, CLK_PS);
    localparam int WR_CYC    = imax(imax(WP_CYC, CW_CYC), imax(DW_CYC, RC_CYC));
    localparam int RD_CYC    = imax(imax(AA_CYC, OE_CYC), RC_CYC);
    localparam int REST_CYC  = RC_CYC;
    localparam int ACC_CYC   = imax(WR_CYC, RD_CYC) + CP_CYC + 1;
    localparam int RUN_LIMIT = BURST_CYC - ACC_CYC - 2 * REST_CYC - 2;
    localparam int TMR_MAX   = imax(PWR_CYC, imax(ACC_CYC, CP_CYC));
    localparam int TW        = $clog2(TMR_MAX + 1);

    ctl_state_t           state, state_nxt;
    logic                 tmr_load, tmr_zero, block, accept;
    logic [TW-1:0]        tmr_val;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q, rd_lanes;
    logic [LANES-1:0]     mask_q;
    logic                 any_lane;

    sram_ctl_timer #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_ctl_run_guard #(.LIMIT(RUN_LIMIT), .REST(REST_CYC)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (state != ST_PWRUP),
        .rest_cycle ((state == ST_IDLE) && !accept),
        .block      (block)
    );

    assign req_ready = (state == ST_IDLE) && !block;
    assign accept    = req_ready && req_valid;
    assign any_lane  = |mask_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= state_nxt;
    end

    // Next state and phase timer control
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            ST_PWRUP:   if (tmr_zero) state_nxt = ST_IDLE;
            ST_IDLE: begin
                if (accept) begin
                    tmr_load  = 1'b1;
                    tmr_val   = req_write ? TW'(WR_CYC - 1) : TW'(RD_CYC - 1);
                    state_nxt = req_write ? ST_WRITE : ST_READ;
                end
            end
            ST_WRITE, ST_READ: begin
                if (tmr_zero) begin
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(CP_CYC - 1);
                    state_nxt = ST_RECOVER;
                end
            end
            ST_RECOVER: if (tmr_zero) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // Memory-side outputs decoded from the state
    always_comb begin
        sram_cs1_n = 1'b1;
        sram_cs2   = 1'b0;
        sram_we_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_be_n  = '1;
        sram_dq_oe = 1'b0;
        unique case (state)
            ST_WRITE: begin
                sram_cs1_n = !any_lane;
                sram_cs2   = any_lane;
                sram_we_n  = !any_lane;
                sram_be_n  = ~mask_q;
                sram_dq_oe = any_lane;
            end
            ST_READ: begin
                sram_cs1_n = !any_lane;
                sram_cs2   = any_lane;
                sram_oe_n  = !any_lane;
                sram_be_n  = ~mask_q;
            end
            default: ;
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_lanes[8*i +: 8] = mask_q[i] ? sram_dq_in[8*i +: 8] : 8'h00;
    end

    // Read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_READ) && tmr_zero;
            if ((state == ST_READ) && tmr_zero)
                rsp_rdata <= rd_lanes;
        end
    end
endmodule

// File: rtl/sram_byte_ctl_chk.sv
module sram_byte_ctl_chk #(
    parameter int PWR_CYC   = 10000,
    parameter int WP_CYC    = 3,
    parameter int CP_CYC    = 1,
    parameter int BURST_CYC = 4000,
    parameter int REST_CYC  = 4,
    parameter int LANES     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             sram_cs1_n,
    input logic             sram_cs2,
    input logic             sram_we_n,
    input logic             sram_oe_n,
    input logic [LANES-1:0] sram_be_n,
    input logic             sram_dq_oe
);
    logic [31:0] since_rst, we_low, cs_high, run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            we_low    <= '0;
            cs_high   <= '0;
            run_len   <= '0;
        end else begin
            if (since_rst < 32'(PWR_CYC)) since_rst <= since_rst + 1;
            we_low <= sram_we_n ? '0 : ((we_low < 32'd255) ? we_low + 1 : we_low);
            if (!sram_cs1_n) cs_high <= '0;
            else if (cs_high < 32'(REST_CYC + CP_CYC)) cs_high <= cs_high + 1;
            if (sram_cs1_n && cs_high + 1 >= 32'(REST_CYC)) run_len <= '0;
            else if (run_len <= 32'(BURST_CYC)) run_len <= run_len + 1;
        end
    end

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 32'(PWR_CYC)) |-> (sram_cs1_n && !sram_cs2 && !req_ready)); // R1
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs1_n && sram_we_n && sram_oe_n)); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low >= 32'(WP_CYC))); // R3
    AST_STROBE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n) |-> !(&sram_be_n)); // R6
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_cs1_n) |-> (cs_high >= 32'(CP_CYC))); // R7
    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !sram_we_n); // R8
    AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R8
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 32'(BURST_CYC)); // R9
endmodule

bind sram_byte_ctl sram_byte_ctl_chk #(
    .PWR_CYC   (PWR_CYC),
    .WP_CYC    (WP_CYC),
    .CP_CYC    (CP_CYC),
    .BURST_CYC (BURST_CYC),
    .REST_CYC  (REST_CYC),
    .LANES     (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .sram_cs1_n (sram_cs1_n),
    .sram_cs2   (sram_cs2),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_be_n  (sram_be_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_byte_ctl_tb.sv
module sram_byte_ctl_tb;
    localparam int EXP_PWR   = 10000;
    localparam int EXP_ACC   = 4;
    localparam int EXP_BURST = 4000;
    localparam int EXP_REST  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready, rsp_valid;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic [15:0] rsp_rdata, sram_dq_out, sram_dq_in;
    logic [18:0] sram_addr;
    logic        sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_be_n;

    int total = 0;
    int bad = 0;

    logic [15:0] mem    [256];
    logic [15:0] shadow [256];

    always #10 clk = ~clk;

    sram_byte_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Memory model
    wire sel = !sram_cs1_n && sram_cs2;
    assign sram_dq_in = (sel && !sram_oe_n) ?
        {(!sram_be_n[1]) ? mem[sram_addr[7:0]][15:8] : 8'hA5,
         (!sram_be_n[0]) ? mem[sram_addr[7:0]][7:0]  : 8'hA5} : 16'hDEAD;

    always @(negedge clk) begin
        if (sel && !sram_we_n && sram_dq_oe) begin
            if (!sram_be_n[0]) mem[sram_addr[7:0]][7:0]  <= sram_dq_out[7:0];
            if (!sram_be_n[1]) mem[sram_addr[7:0]][15:8] <= sram_dq_out[15:8];
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] m, input string tag);
        bit en = (m != 2'b00);
        bit wave_ok = 1, drv_ok = 1, rdy_ok = 1;
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < EXP_ACC; i++) begin
            if (i > 0) @(negedge clk);
            if (sram_cs1_n != !en || sram_cs2 != en || sram_we_n != !en || !sram_oe_n ||
                sram_be_n != ~m || sram_addr != a) wave_ok = 0;
            if (sram_dq_oe != en || (en && sram_dq_out != d)) drv_ok = 0;
            if (req_ready) rdy_ok = 0;
        end
        chk(wave_ok, {tag, " write strobe waveform"}, {30'd0, sram_we_n, sram_cs1_n}, {30'd0, !en, !en});
        chk(drv_ok, "R8 data driven only during write strobe", sram_dq_out, d);
        chk(rdy_ok, "R2 ready low during write", 0, 0);
        @(negedge clk);
        chk(sram_cs1_n && sram_we_n && !sram_dq_oe && !req_ready, "R7 write recovery gap",
            {29'd0, sram_cs1_n, sram_we_n, req_ready}, 32'h6);
        @(negedge clk);
        chk(req_ready, "R7 ready after gap", req_ready, 1);
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [18:0] a, input logic [1:0] m, input string tag);
        bit en = (m != 2'b00);
        bit wave_ok = 1, early_rsp = 0;
        logic [15:0] exp;
        exp = {m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00};
        wait_ready();
        chk(!sram_dq_oe, "R8 bus released before read", sram_dq_oe, 0);
        req_valid = 1; req_write = 0; req_addr = a; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < EXP_ACC; i++) begin
            if (i > 0) @(negedge clk);
            if (sram_cs1_n != !en || sram_cs2 != en || sram_oe_n != !en || !sram_we_n ||
                sram_dq_oe || sram_be_n != ~m || sram_addr != a || req_ready) wave_ok = 0;
            if (rsp_valid) early_rsp = 1;
        end
        chk(wave_ok, {tag, " read strobe waveform"}, {30'd0, sram_oe_n, sram_cs1_n}, {30'd0, !en, !en});
        chk(!early_rsp, "R4 no response before strobes end", early_rsp, 0);
        @(negedge clk);
        chk(rsp_valid && sram_cs1_n && sram_oe_n, "R4 response pulse after strobes", rsp_valid, 1);
        chk(rsp_rdata == exp, {tag, " read data"}, rsp_rdata, exp);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R4 single response cycle", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic t_powerup();
        int n = 0;
        bit quiet = 1;
        req_valid = 1; req_write = 1; req_addr = 19'h5; req_wdata = 16'hFFFF; req_mask = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1;
        while (!req_ready && n < 20000) begin
            if (!sram_cs1_n || sram_cs2 || !sram_we_n) quiet = 0;
            if (n == 20) req_valid = 0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(quiet, "R1 memory deselected during power-up", 0, 0);
        chk(n == EXP_PWR, "R1 first ready cycle", n, EXP_PWR);
        chk(rsp_valid == 0 && sram_dq_oe == 0, "R1 outputs quiet at end of power-up", rsp_valid, 0);
    endtask

    task automatic t_burst();
        int streak = 100, run = 0, max_run = 0, rests = 0;
        repeat (10) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 19'h30; req_mask = 2'b11;
        for (int i = 0; i < 9000; i++) begin
            @(negedge clk);
            if (sram_cs1_n) streak++; else streak = 0;
            if (streak == EXP_REST) rests++;
            if (streak >= EXP_REST) run = 0; else run++;
            if (run > max_run) max_run = run;
        end
        req_valid = 0;
        chk(max_run <= EXP_BURST, "R9 longest run without rest", max_run, EXP_BURST);
        chk(rests >= 1, "R9 rest gap inserted", rests, 1);
        chk(max_run >= 3000, "R9 back-to-back run sustained", max_run, 3000);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'(i * 257) ^ 16'h3C00;
            shadow[i] = 16'(i * 257) ^ 16'h3C00;
        end
        chk(req_ready == 0 && sram_cs1_n == 1 && sram_cs2 == 0, "R1 reset state", req_ready, 0);
        t_powerup();
        do_read(19'h5, 2'b11, "R2 ignored request");
        do_write(19'h12, 16'hBEEF, 2'b11, "R3");
        do_read(19'h12, 2'b11, "R4");
        do_write(19'h20, 16'h1177, 2'b01, "R5 lower");
        do_read(19'h20, 2'b11, "R5 lower-only write");
        do_write(19'h21, 16'h9A42, 2'b10, "R5 upper");
        do_read(19'h21, 2'b11, "R5 upper-only write");
        do_read(19'h21, 2'b10, "R5 upper lane read");
        do_read(19'h20, 2'b01, "R5 lower lane read");
        do_write(19'h12, 16'h0000, 2'b00, "R6 standby");
        do_read(19'h12, 2'b11, "R6 memory unchanged");
        do_read(19'h12, 2'b00, "R6 standby");
        t_burst();
        do_read(19'h40, 2'b11, "R4 after burst");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule